// File: doc/BRIEF.md
# CEC bus bit receiver

This block listens to a single-wire consumer-electronics control (CEC) line and turns the waveform into bytes. It waits for a start bit. It times every following bit from that bit's falling edge, using a microsecond tick supplied from outside. Each data bit is read at its nominal sample point. Each block of eight data bits carries an end-of-message flag and is followed by an acknowledge slot. In that slot the receiver pulls the line low through an open-drain output, unless the host has declared itself busy.

Three optional checks guard the reception:
- the start-bit low phase and period must lie inside their windows;
- a data bit must not stay low past its maximum;
- the three samples taken around each sample point must agree.

Any failed check throws the frame away and reports a one-cycle error pulse with a cause code. Each acknowledged block is handed out as a byte strobe. The final block also raises a done pulse, and the enable bit then clears itself, so the host must re-arm the receiver for the next message.

Top module: `cec_bit_rx`

## Requirements
- R1: Writing the control port with bit 5 set clears every control bit and returns the receiver to idle at that clock edge. For one cycle afterwards, `ctl_q[5]` reads 1 and then returns to 0. A frame cut short this way yields no byte and no acknowledge.
- R2: After `rst_n`, `ctl_q` reads 0, `cec_pull` is released, and no strobe (`rx_valid`, `rx_done`, `rx_err`) is active.
- R3: When the start check (`ctl_q[2]`) is set, an error with code 1 is raised in either of two cases. The first is a start-bit low phase outside 3.5 to 3.9 ms. The second is a start-bit period (falling edge to next falling edge) outside 4.3 to 4.7 ms.
- R4: When the low-time check (`ctl_q[3]`) is set, an error with code 2 is raised if a data or end-of-message bit keeps the line low for more than 1.7 ms after its falling edge.
- R5: When the sampling check (`ctl_q[4]`) is set, an error with code 3 is raised if the line values at 1.00, 1.05 and 1.10 ms after a bit's falling edge are not all equal.
- R6: A bit decodes as the line value 1.05 ms after its falling edge. A block is eight data bits sent most significant bit first, then the end-of-message bit, then the acknowledge slot.
- R7: When the host is not busy (`ctl_q[1]` = 0), `cec_pull` goes high on the clock after the acknowledge slot's falling edge is seen and stays high for exactly 1.5 ms.
- R8: When the host is busy, the acknowledge slot is left released. In that case no `rx_valid` and no `rx_done` is produced, and the enable bit stays set.
- R9: A start bit is accepted only while the enable bit (`ctl_q[0]`) is 1. The enable bit clears itself in the same cycle that `rx_done` is raised.
- R10: Each acknowledged block gives a one-cycle `rx_valid` with its byte on `rx_byte` and its end-of-message bit on `rx_eom`. The block whose end-of-message bit is 1 also raises `rx_done` in that same cycle.
- R11: After an error, the receiver waits for a new start bit and receives the next frame normally. When a check is disabled, the same anomaly raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_us | input | 1 | One-cycle strobe every microsecond |
| cec_in | input | 1 | Synchronized CEC line level |
| cec_pull | output | 1 | 1 pulls the line low (open drain) |
| ctl_we | input | 1 | Control write strobe |
| ctl_wd | input | 6 | Control write data: [5] reset, [4] sample check, [3] low check, [2] start check, [1] host busy, [0] enable |
| ctl_q | output | 6 | Control readback, same layout |
| rx_byte | output | 8 | Last received byte |
| rx_eom | output | 1 | End-of-message bit of that byte |
| rx_valid | output | 1 | One-cycle byte strobe |
| rx_done | output | 1 | One-cycle end-of-message strobe |
| rx_err | output | 1 | One-cycle error strobe |
| rx_err_code | output | 2 | Cause: 1 start timing, 2 low time, 3 sample mismatch |

## Verification
A wrong bit index or a miscounted microsecond usually shows at the ports only at the end of a block. It appears as a byte shifted by one position, a misplaced end-of-message flag, or an acknowledge pulse of the wrong length, roughly 24 ms after the fault. A counter that runs too early or too late shifts the three sample points. That fault appears as a spurious or missing error code within the bit where it happens. A stuck state machine shows as a missing acknowledge on the very next block.

// File: rtl/cec_bit_rx.sv
module cec_bit_rx #(
  parameter int T_SMP0       = 1000,
  parameter int T_SMP1       = 1050,
  parameter int T_SMP2       = 1100,
  parameter int T_LOW_MAX    = 1700,
  parameter int T_ACK        = 1500,
  parameter int T_ST_LO_MIN  = 3500,
  parameter int T_ST_LO_MAX  = 3900,
  parameter int T_ST_PER_MIN = 4300,
  parameter int T_ST_PER_MAX = 4700
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_us,
  input  logic       cec_in,
  output logic       cec_pull,
  input  logic       ctl_we,
  input  logic [5:0] ctl_wd,
  output logic [5:0] ctl_q,
  output logic [7:0] rx_byte,
  output logic       rx_eom,
  output logic       rx_valid,
  output logic       rx_done,
  output logic       rx_err,
  output logic [1:0] rx_err_code
);

  localparam int CW = $clog2(T_ST_PER_MAX + 2);
  localparam logic [CW-1:0] K_TOP  = CW'(T_ST_PER_MAX + 1);
  localparam logic [CW-1:0] K_ONE  = CW'(1);
  localparam logic [CW-1:0] K_S0   = CW'(T_SMP0);
  localparam logic [CW-1:0] K_S1   = CW'(T_SMP1);
  localparam logic [CW-1:0] K_S2   = CW'(T_SMP2);
  localparam logic [CW-1:0] K_LOW  = CW'(T_LOW_MAX);
  localparam logic [CW-1:0] K_ACK  = CW'(T_ACK);
  localparam logic [CW-1:0] K_LMIN = CW'(T_ST_LO_MIN);
  localparam logic [CW-1:0] K_LMAX = CW'(T_ST_LO_MAX);
  localparam logic [CW-1:0] K_PMIN = CW'(T_ST_PER_MIN);
  localparam logic [CW-1:0] K_PMAX = CW'(T_ST_PER_MAX);

  typedef enum logic [1:0] {S_IDLE, S_ST_LO, S_ST_HI, S_BIT} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [3:0]    bidx;
  logic          smp_done, s0, s1, eom_q, acked, cec_d;
  logic [7:0]    shreg;
  logic          en, busy, chk_st, chk_lo, chk_sm, srst_q;

  logic          fall, rise, in_data, hit0, hit1, hit2, hit_ack;
  logic [CW-1:0] cnt_n;
  logic          err_now;
  logic [1:0]    err_c;

  assign fall    = cec_d & ~cec_in;
  assign rise    = ~cec_d & cec_in;
  assign cnt_n   = (cnt == K_TOP) ? cnt : cnt + K_ONE;
  assign hit0    = tick_us && cnt_n == K_S0;
  assign hit1    = tick_us && cnt_n == K_S1;
  assign hit2    = tick_us && cnt_n == K_S2;
  assign hit_ack = tick_us && cnt_n == K_ACK;
  assign in_data = st == S_BIT && bidx <= 4'd8;
  assign ctl_q   = {srst_q, chk_sm, chk_lo, chk_st, busy, en};

  always_comb begin
    err_now = 1'b0;
    err_c   = 2'd0;
    if (st == S_ST_LO && chk_st &&
        ((rise && (cnt < K_LMIN || cnt > K_LMAX)) || (!cec_in && cnt > K_LMAX))) begin
      err_now = 1'b1;
      err_c   = 2'd1;
    end else if (st == S_ST_HI && chk_st &&
        ((fall && (cnt < K_PMIN || cnt > K_PMAX)) || (cec_in && cnt > K_PMAX))) begin
      err_now = 1'b1;
      err_c   = 2'd1;
    end else if (in_data && chk_lo && !cec_in && !fall && cnt > K_LOW) begin
      err_now = 1'b1;
      err_c   = 2'd2;
    end else if (in_data && chk_sm && !smp_done && hit2 && (s0 != s1 || s1 != cec_in)) begin
      err_now = 1'b1;
      err_c   = 2'd3;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bidx <= '0; smp_done <= 1'b0;
      s0 <= 1'b0; s1 <= 1'b0; eom_q <= 1'b0; acked <= 1'b0; cec_d <= 1'b0;
      shreg <= '0; en <= 1'b0; busy <= 1'b0; chk_st <= 1'b0; chk_lo <= 1'b0;
      chk_sm <= 1'b0; srst_q <= 1'b0; cec_pull <= 1'b0; rx_byte <= '0;
      rx_eom <= 1'b0; rx_valid <= 1'b0; rx_done <= 1'b0; rx_err <= 1'b0;
      rx_err_code <= '0;
    end else if (ctl_we && ctl_wd[5]) begin
      st <= S_IDLE; cnt <= '0; bidx <= '0; smp_done <= 1'b0;
      s0 <= 1'b0; s1 <= 1'b0; eom_q <= 1'b0; acked <= 1'b0; cec_d <= 1'b0;
      shreg <= '0; en <= 1'b0; busy <= 1'b0; chk_st <= 1'b0; chk_lo <= 1'b0;
      chk_sm <= 1'b0; srst_q <= 1'b1; cec_pull <= 1'b0; rx_byte <= '0;
      rx_eom <= 1'b0; rx_valid <= 1'b0; rx_done <= 1'b0; rx_err <= 1'b0;
      rx_err_code <= '0;
    end else begin
      srst_q   <= 1'b0;
      rx_valid <= 1'b0;
      rx_done  <= 1'b0;
      rx_err   <= 1'b0;
      cec_d    <= cec_in;
      if (ctl_we) {chk_sm, chk_lo, chk_st, busy, en} <= ctl_wd[4:0];
      if (tick_us) cnt <= cnt_n;
      if (err_now) begin
        rx_err      <= 1'b1;
        rx_err_code <= err_c;
        st          <= S_IDLE;
        cec_pull    <= 1'b0;
      end else begin
        case (st)
          S_IDLE: if (en && fall) begin
            st  <= S_ST_LO;
            cnt <= '0;
          end
          S_ST_LO: if (rise) st <= S_ST_HI;
          S_ST_HI: if (fall) begin
            st       <= S_BIT;
            cnt      <= '0;
            bidx     <= 4'd0;
            smp_done <= 1'b0;
          end
          S_BIT: begin
            if (fall && smp_done) begin
              cnt      <= '0;
              smp_done <= 1'b0;
              bidx     <= bidx + 4'd1;
              if (bidx == 4'd8) begin
                acked    <= !busy;
                cec_pull <= !busy;
              end
            end else if (!smp_done && bidx == 4'd9) begin
              if (hit_ack) begin
                cec_pull <= 1'b0;
                smp_done <= 1'b1;
                bidx     <= 4'hF;
                if (acked) begin
                  rx_valid <= 1'b1;
                  rx_byte  <= shreg;
                  rx_eom   <= eom_q;
                end
                if (eom_q) begin
                  st <= S_IDLE;
                  if (acked) begin
                    rx_done <= 1'b1;
                    en      <= 1'b0;
                  end
                end
              end
            end else if (!smp_done) begin
              if (hit0) s0 <= cec_in;
              if (hit1) begin
                s1 <= cec_in;
                if (bidx < 4'd8) shreg <= {shreg[6:0], cec_in};
                else eom_q <= cec_in;
              end
              if (hit2) smp_done <= 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_srst_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> !srst_q);
  p_start_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && rx_err_code == 2'd1) |-> $past(chk_st));
  p_pull_in_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cec_pull |-> (st == S_BIT && bidx == 4'd9));
  p_pull_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cec_pull) |-> $past(!busy));
  p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> !en);
  p_done_final_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> (rx_valid && rx_eom));
  p_err_alone_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> (rx_err_code != 2'd0 && !rx_valid && !rx_done));

endmodule

// File: tb/test_cec_bit_rx.sv
module test_cec_bit_rx;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       drv = 1'b1;
  logic       bus;
  logic       cec_pull;
  logic       ctl_we = 1'b0;
  logic [5:0] ctl_wd = '0;
  logic [5:0] ctl_q;
  logic [7:0] rx_byte;
  logic       rx_eom, rx_valid, rx_done, rx_err;
  logic [1:0] rx_err_code;

  assign bus = drv & ~cec_pull;

  cec_bit_rx #(
    .T_SMP0(100), .T_SMP1(105), .T_SMP2(110), .T_LOW_MAX(170), .T_ACK(150),
    .T_ST_LO_MIN(350), .T_ST_LO_MAX(390), .T_ST_PER_MIN(430), .T_ST_PER_MAX(470)
  ) i_cec_bit_rx (
    .clk(clk), .rst_n(rst_n), .tick_us(tick), .cec_in(bus), .cec_pull(cec_pull),
    .ctl_we(ctl_we), .ctl_wd(ctl_wd), .ctl_q(ctl_q), .rx_byte(rx_byte),
    .rx_eom(rx_eom), .rx_valid(rx_valid), .rx_done(rx_done), .rx_err(rx_err),
    .rx_err_code(rx_err_code)
  );

  int total = 0, bad = 0;
  int nv = 0, nd = 0, ne = 0, last_code = 0;
  logic [7:0] got [0:7];
  logic       geom [0:7];
  int ack_len;
  bit ack_mid;

  always @(negedge clk) if (rst_n) begin
    if (rx_valid) begin got[nv % 8] = rx_byte; geom[nv % 8] = rx_eom; nv++; end
    if (rx_done) nd++;
    if (rx_err) begin ne++; last_code = int'(rx_err_code); end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(bit lvl, int n);
    drv = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] v);
    ctl_wd = v; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic start(int lo, int per);
    drive(1'b0, lo);
    drive(1'b1, per - lo);
  endtask

  task automatic raw_bit(int lo);
    drive(1'b0, lo);
    drive(1'b1, 240 - lo);
  endtask

  task automatic ack_slot();
    ack_len = 0;
    ack_mid = 1'b0;
    for (int c = 0; c < 240; c++) begin
      drv = (c < 60) ? 1'b0 : 1'b1;
      if (cec_pull) ack_len++;
      if (c == 100) ack_mid = cec_pull;
      @(negedge clk);
    end
  endtask

  task automatic block(logic [7:0] b, bit eom, int first_lo);
    for (int i = 7; i >= 0; i--) begin
      if (i == 7 && first_lo > 0) raw_bit(first_lo);
      else raw_bit(b[i] ? 60 : 150);
    end
    raw_bit(eom ? 60 : 150);
    ack_slot();
  endtask

  task automatic run_all();
    int v0, d0, e0, acks;
    logic [7:0] b [0:2];
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 ctl_q after reset", int'(ctl_q), 0);
    chk("R2 pull after reset", int'(cec_pull), 0);
    chk("R2 strobes after reset", int'({rx_valid, rx_done, rx_err}), 0);

    // R9: disabled receiver ignores a frame
    v0 = nv; start(370, 450); block(8'h5A, 1'b1, 0); drive(1'b1, 300);
    chk("R9 no byte while disabled", nv - v0, 0);
    chk("R9 no ack while disabled", ack_len, 0);

    // sweep over start timings and byte patterns with all checks on
    for (int f = 0; f < 8; f++) begin
      b[0] = 8'((f * 73 + 5) & 255);
      b[1] = ~b[0];
      b[2] = 8'((f * 17) & 255);
      wr(6'h1D);
      v0 = nv; d0 = nd; e0 = ne; acks = 0;
      start(355 + f * 4, 435 + f * 4);
      for (int k = 0; k < 3; k++) begin
        block(b[k], k == 2, 0);
        if (ack_mid) acks++;
        if (f == 0) chk("R7 ack length", ack_len, 150);
      end
      drive(1'b1, 300);
      chk("R10 byte count", nv - v0, 3);
      for (int k = 0; k < 3; k++) begin
        chk("R6 byte value", int'(got[(v0 + k) % 8]), int'(b[k]));
        chk("R6 eom flag", int'(geom[(v0 + k) % 8]), (k == 2) ? 1 : 0);
      end
      chk("R7 acks given", acks, 3);
      chk("R10 done count", nd - d0, 1);
      chk("R11 no error on clean frame", ne - e0, 0);
      chk("R9 enable self-cleared", int'(ctl_q[0]), 0);
    end

    // R8: busy host
    wr(6'h03); v0 = nv; d0 = nd; acks = 0;
    start(370, 450);
    block(8'hC3, 1'b0, 0); if (ack_mid) acks++;
    block(8'h3C, 1'b1, 0); if (ack_mid) acks++;
    drive(1'b1, 300);
    chk("R8 no ack when busy", acks, 0);
    chk("R8 no byte when busy", nv - v0, 0);
    chk("R8 no done when busy", nd - d0, 0);
    chk("R8 enable kept", int'(ctl_q[0]), 1);

    // R3: start timing errors
    wr(6'h05); e0 = ne;
    start(300, 450); drive(1'b1, 300);
    chk("R3 short start low count", ne - e0, 1);
    chk("R3 short start low code", last_code, 1);
    e0 = ne;
    drive(1'b0, 370); drive(1'b1, 500);
    chk("R3 long period count", ne - e0, 1);
    chk("R3 long period code", last_code, 1);
    // R11: recovery, and start check off accepts the short start
    v0 = nv; start(370, 450); block(8'h81, 1'b1, 0); drive(1'b1, 300);
    chk("R11 recovery after start error", int'(got[v0 % 8]), 8'h81);
    wr(6'h01); v0 = nv; e0 = ne;
    start(300, 450); block(8'h42, 1'b1, 0); drive(1'b1, 300);
    chk("R11 start check off no error", ne - e0, 0);
    chk("R11 start check off byte", int'(got[v0 % 8]), 8'h42);

    // R4: low-time error
    wr(6'h09); e0 = ne; v0 = nv;
    start(370, 450); raw_bit(200); drive(1'b1, 300);
    chk("R4 low error count", ne - e0, 1);
    chk("R4 low error code", last_code, 2);
    chk("R4 no byte after abort", nv - v0, 0);
    v0 = nv; start(370, 450); block(8'hE7, 1'b1, 0); drive(1'b1, 300);
    chk("R11 recovery after low error", int'(got[v0 % 8]), 8'hE7);
    wr(6'h01); v0 = nv; e0 = ne;
    start(370, 450); block(8'h7F, 1'b1, 200); drive(1'b1, 300);
    chk("R11 low check off no error", ne - e0, 0);
    chk("R6 long low bit decodes 0", int'(got[v0 % 8]), 8'h7F);

    // R5: sample mismatch
    wr(6'h11); e0 = ne;
    start(370, 450); raw_bit(103); drive(1'b1, 300);
    chk("R5 sample error count", ne - e0, 1);
    chk("R5 sample error code", last_code, 3);
    wr(6'h01); v0 = nv; e0 = ne;
    start(370, 450); block(8'h80, 1'b1, 103); drive(1'b1, 300);
    chk("R11 sample check off no error", ne - e0, 0);
    chk("R6 middle sample decides", int'(got[v0 % 8]), 8'h80);

    // R1: soft reset mid-frame
    wr(6'h1F); v0 = nv;
    start(370, 450); raw_bit(60); raw_bit(150); raw_bit(60);
    wr(6'h20);
    chk("R1 reset bit reads one", int'(ctl_q), 6'h20);
    @(negedge clk);
    chk("R1 reset bit self-clears", int'(ctl_q), 0);
    for (int i = 0; i < 6; i++) raw_bit(60);
    ack_slot(); drive(1'b1, 300);
    chk("R1 no byte after reset", nv - v0, 0);
    chk("R1 no ack after reset", ack_len, 0);
    wr(6'h01); v0 = nv;
    start(370, 450); block(8'h96, 1'b1, 0); drive(1'b1, 300);
    chk("R1 receiver usable after reset", int'(got[v0 % 8]), 8'h96);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule